// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Step Stop Period

This block turns bytes into asynchronous serial frames. It runs from the system clock and advances only on a one-cycle enable that pulses at sixteen times the bit rate, so every bit lasts exactly sixteen enable ticks. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period. The stop period is set by a 4-bit code in steps of one sixteenth of a bit time.

Software or a bus decoder outside the block writes bytes into a one-entry holding register. The block also takes one-cycle enable and disable commands and an optional clear-to-send gate. It reports whether it can take another byte and whether all transmission has finished. Baud generation and flow-control outputs belong to the surrounding logic.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset `txd_o` is 1, `tx_rdy_o` is 0 (the transmitter starts disabled) and `tx_empty_o` is 1.
- R2: A pulse on `tx_en_cmd_i` enables the transmitter. A pulse on `tx_dis_cmd_i` disables it and wins if both arrive together. `tx_rdy_o` is 1 exactly when the transmitter is enabled and the holding register is empty.
- R3: A write (`wr_en_i` high for one cycle) is ignored while the transmitter is disabled or the holding register is full. An ignored write never produces a frame.
- R4: A frame is one start bit at 0, then data bits least significant first, then parity if enabled, then the stop period at 1. Each of these bits lasts 16 ticks. `char_len_i` selects the number of data bits: 00=5, 01=6, 10=7, 11=8. Unsent upper bits are ignored.
- R5: `par_mode_i` 00 adds a computed parity bit: with `par_odd_i`=0 the data bits plus parity hold an even number of ones, and with `par_odd_i`=1 an odd number. 01 adds a forced parity bit equal to `par_odd_i`. 10 and 11 add no parity bit.
- R6: The stop period lasts 9+code ticks for codes 0 to 7 and 17+code ticks for codes 8 to 15, where code is `stop_code_i`.
- R7: With 5-bit characters, codes 0 to 7 add 8 more ticks to the stop period. Codes 8 to 15 are unchanged.
- R8: A byte written while a frame is in progress waits in the holding register. Its start bit begins on the tick right after the last stop tick, with no idle gap. `tx_rdy_o` rises again as soon as the shifter takes the byte.
- R9: When `cts_en_i` is 1, a new frame starts only while `cts_i` is 1. A frame that has already started always completes even if `cts_i` falls.
- R10: A disable command lets the frame in progress and any pending byte finish. After that the line stays at 1.
- R11: `tx_empty_o` is 1 exactly when the holding register is empty and no frame is in progress. While it is 1, `txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulse at 16x the bit rate |
| wr_en_i | input | 1 | Holding register write strobe |
| wr_data_i | input | DATA_W | Byte to send |
| tx_en_cmd_i | input | 1 | Enable command pulse |
| tx_dis_cmd_i | input | 1 | Disable command pulse |
| cts_en_i | input | 1 | Gate frame starts on `cts_i` |
| cts_i | input | 1 | Clear to send, active high |
| char_len_i | input | 2 | Data bits per character |
| par_mode_i | input | 2 | Parity mode |
| par_odd_i | input | 1 | Parity sense or forced value |
| stop_code_i | input | CODE_W | Stop period code |
| txd_o | output | 1 | Serial output, idle high |
| tx_rdy_o | output | 1 | Holding register can take a byte |
| tx_empty_o | output | 1 | Nothing pending or in flight |

## Verification
Most faults in the shifter state show up within one bit time, as a bit edge that lands one or more ticks off the 16-tick grid. To make such shifts visible, the line is recorded once per tick. A wrong stop count or a lost pending byte only shows when the next start bit arrives. For that reason every configuration sends two back-to-back frames and requires the second start edge on an exact tick. A fault in the enable or holding flag shows at `tx_rdy_o` or `tx_empty_o` on the next clock, or as a frame that appears or goes missing after a write that should have been dropped.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int OVS = 16;              // ticks per bit
  localparam int STOP_SHORT = OVS / 2 + 1;
  localparam int STOP_LONG  = OVS + 1;
  localparam int STOP_EXT   = OVS / 2;

  typedef enum logic [1:0] {
    PAR_ON    = 2'b00,
    PAR_FORCE = 2'b01,
    PAR_NONE  = 2'b10,
    PAR_NONE2 = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_stop_len.sv
module uart_tx_stop_len
  import uart_tx_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int TICK_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              short_char_i,
  output logic [TICK_W-1:0] ticks_o
);
  logic long_range;
  assign long_range = code_i[CODE_W-1];

  always_comb begin
    ticks_o = TICK_W'(code_i) + (long_range ? TICK_W'(STOP_LONG) : TICK_W'(STOP_SHORT));
    if (!long_range && short_char_i) ticks_o = ticks_o + TICK_W'(STOP_EXT);
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_cmd_i,
  input  logic              dis_cmd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              rdy_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              on_q, full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = wr_i && on_q && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (dis_cmd_i)     on_q <= 1'b0;
      else if (en_cmd_i) on_q <= 1'b1;
      if (accept) begin
        full_q <= 1'b1;
        data_q <= wdata_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign rdy_o  = on_q && !full_q;
  assign full_o = full_q;
  assign data_o = data_q;

  AST_OFF_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_q && !full_q) |=> !full_q); // R3
  AST_TAKE_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q); // R8
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICK_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cts_ok_i,
  input  logic [1:0]        char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              par_odd_i,
  input  logic [TICK_W-1:0] stop_ticks_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int IDX_W = $clog2(DATA_W);

  tx_state_e         state_q;
  logic [TICK_W-1:0] cnt_q, stop_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_en_q, par_bit_q, txd_q;

  logic [DATA_W-1:0] mask, masked;
  logic              par_en, par_bit, bit_end, frame_end;
  par_mode_e         pm;

  always_comb begin
    pm      = par_mode_e'(par_mode_i);
    mask    = {DATA_W{1'b1}} >> (2'd3 - char_len_i);
    masked  = data_i & mask;
    par_en  = (pm == PAR_ON) || (pm == PAR_FORCE);
    par_bit = (pm == PAR_FORCE) ? par_odd_i : ((^masked) ^ par_odd_i);
  end

  assign bit_end   = cnt_q == TICK_W'(OVS - 1);
  assign frame_end = (state_q == ST_STOP) && (cnt_q == stop_q - TICK_W'(1));
  assign take_o    = tick_i && full_i && cts_ok_i && ((state_q == ST_IDLE) || frame_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      stop_q    <= '0;
      idx_q     <= '0;
      last_q    <= '0;
      sh_q      <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      txd_q     <= 1'b1;
    end else if (take_o) begin
      state_q   <= ST_START;
      cnt_q     <= '0;
      stop_q    <= stop_ticks_i;
      last_q    <= IDX_W'(4) + IDX_W'(char_len_i);
      sh_q      <= masked;
      par_en_q  <= par_en;
      par_bit_q <= par_bit;
      txd_q     <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + TICK_W'(1);
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          txd_q <= 1'b1;
        end
        ST_START: if (bit_end) begin
          cnt_q   <= '0;
          idx_q   <= '0;
          state_q <= ST_DATA;
          txd_q   <= sh_q[0];
        end
        ST_DATA: if (bit_end) begin
          cnt_q <= '0;
          if (idx_q == last_q) begin
            state_q <= par_en_q ? ST_PAR : ST_STOP;
            txd_q   <= par_en_q ? par_bit_q : 1'b1;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            sh_q  <= sh_q >> 1;
            txd_q <= sh_q[1];
          end
        end
        ST_PAR: if (bit_end) begin
          cnt_q   <= '0;
          state_q <= ST_STOP;
          txd_q   <= 1'b1;
        end
        ST_STOP: if (frame_end) begin
          cnt_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign txd_o  = txd_q;

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> txd_q); // R10
  AST_STOP_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> txd_q); // R6
  AST_STOP_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (cnt_q < stop_q)); // R6
  AST_MOVE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q)); // R4
  AST_CTS_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !cts_ok_i) |=> (state_q == ST_IDLE)); // R9
endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_cmd_i,
  input  logic              tx_dis_cmd_i,
  input  logic              cts_en_i,
  input  logic              cts_i,
  input  logic [1:0]        char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              par_odd_i,
  input  logic [CODE_W-1:0] stop_code_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o
);
  localparam int TICK_W = $clog2(STOP_LONG + (1 << CODE_W));

  logic              full, take, busy;
  logic [DATA_W-1:0] hold_data;
  logic [TICK_W-1:0] stop_ticks;

  uart_tx_stop_len #(.CODE_W(CODE_W), .TICK_W(TICK_W)) i_stop_len (
    .code_i       (stop_code_i),
    .short_char_i (char_len_i == 2'b00),
    .ticks_o      (stop_ticks)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_cmd_i  (tx_en_cmd_i),
    .dis_cmd_i (tx_dis_cmd_i),
    .wr_i      (wr_en_i),
    .wdata_i   (wr_data_i),
    .take_i    (take),
    .rdy_o     (tx_rdy_o),
    .full_o    (full),
    .data_o    (hold_data)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .TICK_W(TICK_W)) i_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick16_i),
    .full_i       (full),
    .data_i       (hold_data),
    .cts_ok_i     (!cts_en_i || cts_i),
    .char_len_i   (char_len_i),
    .par_mode_i   (par_mode_i),
    .par_odd_i    (par_odd_i),
    .stop_ticks_i (stop_ticks),
    .take_o       (take),
    .busy_o       (busy),
    .txd_o        (txd_o)
  );

  assign tx_empty_o = !full && !busy;

  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o); // R11
  AST_RDY_NOT_BUSY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rdy_o |-> !full); // R2
endmodule

// File: tb/test_uart_tx_frac.sv
module test_uart_tx_frac;
  localparam int LOG_N = 2048;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr_en = 1'b0, en_cmd = 1'b0, dis_cmd = 1'b0, cts_en = 1'b0, cts = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = 2'b11, par_mode = 2'b10;
  logic par_odd = 1'b0;
  logic [3:0] stop_code = 4'h7;
  logic txd, tx_rdy, tx_empty;

  int n_chk = 0, n_err = 0;
  logic log_q [LOG_N];
  int log_n = 0;
  bit log_clr = 1'b0;

  always #10 clk = ~clk;

  uart_tx_frac i_uart_tx_frac (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_en_cmd_i(en_cmd), .tx_dis_cmd_i(dis_cmd),
    .cts_en_i(cts_en), .cts_i(cts),
    .char_len_i(char_len), .par_mode_i(par_mode), .par_odd_i(par_odd),
    .stop_code_i(stop_code),
    .txd_o(txd), .tx_rdy_o(tx_rdy), .tx_empty_o(tx_empty)
  );

  // tick every second clock; line recorded once per tick, after the ticked edge
  initial begin
    forever begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (log_clr) begin log_n = 0; log_clr = 1'b0; end
      if (log_n < LOG_N) begin log_q[log_n] = txd; log_n++; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    log_clr = 1'b1;
    while (log_clr) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_en();
    @(negedge clk); en_cmd = 1'b1;
    @(negedge clk); en_cmd = 1'b0;
  endtask

  task automatic pulse_dis();
    @(negedge clk); dis_cmd = 1'b1;
    @(negedge clk); dis_cmd = 1'b0;
  endtask

  task automatic wait_rdy(input string req);
    int n = 0;
    while (!tx_rdy && n < 4000) begin @(negedge clk); n++; end
    chk(tx_rdy, req, "tx_rdy wait", tx_rdy, 1);
  endtask

  task automatic wait_empty(input string req);
    int n = 0;
    while (!tx_empty && n < 4000) begin @(negedge clk); n++; end
    chk(tx_empty, req, "tx_empty wait", tx_empty, 1);
    repeat (40) @(negedge clk);
  endtask

  function automatic int exp_stop(input int code, input int nb);
    if (code < 8) return 9 + code + ((nb == 5) ? 8 : 0);
    return 17 + code;
  endfunction

  function automatic int find_low(input int from);
    for (int i = from; i < log_n; i++) if (log_q[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic int frame_len(input int nb, input int pm, input int stp);
    return (1 + nb + ((pm < 2) ? 1 : 0)) * 16 + stp;
  endfunction

  task automatic chk_frame(input int st, input int nb, input logic [7:0] d, input int pm,
                           input logic po, input int stp, input bit nxt, input string req);
    logic bits [10];
    int nbit, len, bad, pos;
    logic par;
    bits[0] = 1'b0;
    par = 1'b0;
    for (int k = 0; k < nb; k++) begin bits[k + 1] = d[k]; par = par ^ d[k]; end
    nbit = 1 + nb;
    if (pm == 0) begin bits[nbit] = par ^ po; nbit++; end
    else if (pm == 1) begin bits[nbit] = po; nbit++; end
    len = nbit * 16 + stp;
    bad = -1;
    if (st < 0 || st + len >= log_n) bad = 0;
    else begin
      for (int i = 0; i < len; i++) begin
        pos = i / 16;
        if (bad < 0 && log_q[st + i] !== ((pos < nbit) ? bits[pos] : 1'b1)) bad = i;
      end
      if (bad < 0 && log_q[st + len] !== (nxt ? 1'b0 : 1'b1)) bad = len;
    end
    chk(bad < 0, req, $sformatf("frame d=%02h mismatch at tick", d), bad, -1);
  endtask

  task automatic send_pair(input logic [1:0] cl, input logic [1:0] pm, input logic po,
                           input logic [3:0] sc, input logic [7:0] d1, input logic [7:0] d2,
                           input string req);
    int nb, stp, s1, s2;
    char_len = cl; par_mode = pm; par_odd = po; stop_code = sc;
    nb = 5 + int'(cl);
    stp = exp_stop(int'(sc), nb);
    clear_log();
    write(d1);
    wait_rdy("R8");
    chk(!tx_empty, "R11", "tx_empty while sending", tx_empty, 0);
    write(d2);
    write(8'h99); // holding full: dropped (R3)
    wait_empty("R11");
    s1 = find_low(0);
    chk_frame(s1, nb, d1, int'(pm), po, stp, 1'b1, req);
    s2 = s1 + frame_len(nb, int'(pm), stp);
    chk_frame(s2, nb, d2, int'(pm), po, stp, 1'b0, req);
    chk(find_low(s2 + 1 + frame_len(nb, int'(pm), stp) - 1) < 0, "R3", "extra frame after full write", 1, 0);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R1", "txd", txd, 1);
    chk(tx_rdy == 1'b0, "R1", "tx_rdy", tx_rdy, 0);
    chk(tx_empty == 1'b1, "R1", "tx_empty", tx_empty, 1);
  endtask

  task automatic t_disabled_write();
    clear_log();
    write(8'h00);
    repeat (100) @(negedge clk);
    chk(tx_empty == 1'b1, "R3", "empty after write while off", tx_empty, 1);
    chk(find_low(0) < 0, "R3", "frame while off", find_low(0), -1);
  endtask

  task automatic t_enable();
    pulse_en();
    chk(tx_rdy == 1'b1, "R2", "tx_rdy after enable", tx_rdy, 1);
    chk(tx_empty == 1'b1, "R11", "empty after enable", tx_empty, 1);
    @(negedge clk); en_cmd = 1'b1; dis_cmd = 1'b1;
    @(negedge clk); en_cmd = 1'b0; dis_cmd = 1'b0;
    chk(tx_rdy == 1'b0, "R2", "disable wins", tx_rdy, 0);
    pulse_en();
  endtask

  task automatic t_cts();
    int s1, len;
    char_len = 2'b11; par_mode = 2'b10; stop_code = 4'h7;
    len = frame_len(8, 2, 16);
    cts_en = 1'b1; cts = 1'b0;
    clear_log();
    write(8'h5A);
    repeat (100) @(negedge clk);
    chk(find_low(0) < 0, "R9", "start while cts low", find_low(0), -1);
    chk(tx_empty == 1'b0, "R9", "byte pending", tx_empty, 0);
    clear_log();
    cts = 1'b1;
    wait_rdy("R9");
    write(8'hC3);
    repeat (20) @(negedge clk);
    cts = 1'b0;
    repeat (500) @(negedge clk);
    s1 = find_low(0);
    chk_frame(s1, 8, 8'h5A, 2, 1'b0, 16, 1'b0, "R9");
    chk(find_low(s1 + len) < 0, "R9", "second start while cts low", 1, 0);
    chk(tx_empty == 1'b0, "R9", "second pending", tx_empty, 0);
    clear_log();
    cts = 1'b1;
    wait_empty("R9");
    chk_frame(find_low(0), 8, 8'hC3, 2, 1'b0, 16, 1'b0, "R9");
    cts_en = 1'b0;
  endtask

  task automatic t_disable();
    int s1;
    char_len = 2'b10; par_mode = 2'b00; par_odd = 1'b1; stop_code = 4'h2;
    clear_log();
    write(8'h11);
    wait_rdy("R10");
    write(8'h6E);
    pulse_dis();
    chk(tx_rdy == 1'b0, "R2", "tx_rdy after disable", tx_rdy, 0);
    wait_empty("R10");
    s1 = find_low(0);
    chk_frame(s1, 7, 8'h11, 0, 1'b1, 11, 1'b1, "R10");
    chk_frame(s1 + frame_len(7, 0, 11), 7, 8'h6E, 0, 1'b1, 11, 1'b0, "R10");
    chk(txd == 1'b1, "R10", "line idle after disable", txd, 1);
    t_disabled_write();
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_write();
    t_enable();
    send_pair(2'b11, 2'b10, 1'b0, 4'h7, 8'hA5, 8'h3C, "R4 R6 R8");
    send_pair(2'b10, 2'b00, 1'b0, 4'hF, 8'h53, 8'h7F, "R5 R6");
    send_pair(2'b01, 2'b00, 1'b1, 4'h3, 8'h2A, 8'h15, "R5 R6");
    send_pair(2'b11, 2'b01, 1'b1, 4'h8, 8'h00, 8'hFF, "R5 R6");
    send_pair(2'b11, 2'b01, 1'b0, 4'hC, 8'hFF, 8'h81, "R5 R6");
    send_pair(2'b00, 2'b10, 1'b0, 4'h0, 8'h1B, 8'hE4, "R7 R4");
    send_pair(2'b00, 2'b11, 1'b0, 4'h9, 8'h0F, 8'h30, "R7 R5");
    send_pair(2'b00, 2'b00, 1'b1, 4'h7, 8'h16, 8'h09, "R7 R5");
    t_cts();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule